// File: doc/BRIEF.md
# Key Event Queue

This block buffers key events between a keypad scanner and a host-facing register core. It is a 16-slot circular byte queue kept as a start pointer and a fill count. Each stored byte carries a 7-bit key code in bits 6..0 and a press/release flag in bit 7. The scanner side presents one event per cycle with a push strobe. The block signals an accepted event with a keypad-event strobe and a rejected one with an overflow strobe. The register core keeps its own sticky status and error bits from these strobes.

The host side reads in two ways. A consuming read first advances the start pointer and then returns the byte at the new start. The slot under the start pointer therefore always holds the most recently serviced event. A peek read returns the byte at a chosen offset from the start pointer and leaves the state unchanged. Both read paths are combinational from the current state. A consuming read takes effect at the clock edge on which it is asserted.

The register core can flush the queue. It can also lock out the scanner by reporting that its error status and its overflow error bit are both set.

Top module: `key_event_queue`

## Requirements
- R1: After reset the fill level is 0 and a peek at any offset returns 0x00.
- R2: An accepted push writes {release flag, code} to slot (start + level) mod 16. It raises `key_event_o` in that cycle, and the level rises by one at the next edge.
- R3: A push while the level is 16 and no consuming read takes effect is dropped. It raises `ovf_pulse_o` in that cycle and not `key_event_o`, and the level stays 16.
- R4: While `err_active_i` and `ovf_err_i` are both high, a push is ignored. Neither strobe rises and the level does not change.
- R5: While the level is 0 or 1, `pop_data_o` is 0x00. A consuming read then changes neither pointer nor level.
- R6: While the level is 2 or more, `pop_data_o` is the byte at slot (start + 1) mod 16. A consuming read moves start to that slot and lowers the level by one.
- R7: A peek at offset k returns 0x00 when k ≥ level, and otherwise returns the byte at slot (start + k) mod 16. Peeking never changes the pointers or the level.
- R8: `flush_i` sets start and level to 0 at the next edge. It takes priority over a push and a consuming read in the same cycle, and neither strobe rises.
- R9: A push and a consuming read in the same cycle both take effect, and the level is unchanged. This holds even at level 16, where the push lands in the slot just vacated.
- R10: Slot indices wrap modulo 16, so data stays correct after the start pointer passes slot 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Scanner offers an event this cycle |
| push_code_i | input | 7 | Key code of the offered event |
| push_rel_i | input | 1 | Event state flag stored in bit 7 |
| err_active_i | input | 1 | Register core error status bit |
| ovf_err_i | input | 1 | Register core sticky overflow error bit |
| pop_i | input | 1 | Consuming read this cycle |
| pop_data_o | output | 8 | Byte a consuming read returns |
| peek_off_i | input | 5 | Peek offset from the start pointer |
| peek_data_o | output | 8 | Byte at the peek offset |
| flush_i | input | 1 | Empty the queue |
| key_event_o | output | 1 | Push accepted this cycle |
| ovf_pulse_o | output | 1 | Push dropped because the queue is full |
| level_o | output | 5 | Current number of stored entries |

## Verification
On every cycle the assertions check several rules:
- the bound on the level
- the overflow strobe on a full push, and that the level holds afterward
- silence of both strobes under lockout
- zero read data for a low level or an out-of-range peek
- the one-step level rise after an accepted push
- the effect of a flush

Only the bench's scenarios show that the stored bytes are right: the bit packing of code and flag, the pre-advance of the consuming read that leaves the serviced event at the start slot, wraparound past slot 15, and the slot reuse when a push meets a consuming read at full level.

// File: rtl/key_event_queue.sv
module key_event_queue #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic            push_rel_i,
  input  logic            err_active_i,
  input  logic            ovf_err_i,
  input  logic            pop_i,
  output logic [CODE_W:0] pop_data_o,
  input  logic [AW:0]     peek_off_i,
  output logic [CODE_W:0] peek_data_o,
  input  logic            flush_i,
  output logic            key_event_o,
  output logic            ovf_pulse_o,
  output logic [AW:0]     level_o
);
  localparam int BW = CODE_W + 1;

  logic [BW-1:0] slots [DEPTH];
  logic [AW-1:0] start_q;
  logic [AW:0]   len_q;

  logic locked, full, pop_ok, push_try, push_ok;
  logic [AW-1:0] wr_idx, next_idx, peek_idx;

  assign locked   = err_active_i & ovf_err_i;
  assign full     = (len_q == (AW+1)'(DEPTH));
  assign pop_ok   = pop_i & (len_q > (AW+1)'(1)) & ~flush_i;
  assign push_try = push_i & ~locked & ~flush_i;
  assign push_ok  = push_try & (~full | pop_ok);

  assign wr_idx   = start_q + len_q[AW-1:0];
  assign next_idx = start_q + AW'(1);
  assign peek_idx = start_q + peek_off_i[AW-1:0];

  assign key_event_o = push_ok;
  assign ovf_pulse_o = push_try & full & ~pop_ok;
  assign level_o     = len_q;
  assign pop_data_o  = (len_q > (AW+1)'(1)) ? slots[next_idx] : '0;
  assign peek_data_o = (peek_off_i < len_q) ? slots[peek_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
    end else if (flush_i) begin
      start_q <= '0;
      len_q   <= '0;
    end else begin
      if (pop_ok) start_q <= next_idx;
      len_q <= len_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_idx] <= {push_rel_i, push_code_i};
  end
endmodule

// File: rtl/key_event_queue_chk.sv
module key_event_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_i,
  input logic            err_active_i,
  input logic            ovf_err_i,
  input logic            pop_i,
  input logic            flush_i,
  input logic [CODE_W:0] pop_data_o,
  input logic [AW:0]     peek_off_i,
  input logic [CODE_W:0] peek_data_o,
  input logic            key_event_o,
  input logic            ovf_pulse_o,
  input logic [AW:0]     level_o
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= (AW+1)'(DEPTH));

  p_event_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_event_o && !pop_i && !flush_i |=> level_o == $past(level_o) + (AW+1)'(1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !(err_active_i && ovf_err_i) && !flush_i && !pop_i
      && level_o == (AW+1)'(DEPTH) |-> ovf_pulse_o && !key_event_o);

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> level_o == (AW+1)'(DEPTH));

  p_lockout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_active_i && ovf_err_i |-> !key_event_o && !ovf_pulse_o);

  p_pop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= (AW+1)'(1) |-> pop_data_o == '0);

  p_pop_low_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && !flush_i && level_o <= (AW+1)'(1) |=> $stable(level_o));

  p_peek_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    peek_off_i >= level_o |-> peek_data_o == '0);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> level_o == '0);

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !key_event_o && !ovf_pulse_o);
endmodule

bind key_event_queue key_event_queue_chk #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .err_active_i(err_active_i),
  .ovf_err_i(ovf_err_i), .pop_i(pop_i), .flush_i(flush_i),
  .pop_data_o(pop_data_o), .peek_off_i(peek_off_i), .peek_data_o(peek_data_o),
  .key_event_o(key_event_o), .ovf_pulse_o(ovf_pulse_o), .level_o(level_o));

// File: tb/key_event_queue_test.sv
`timescale 1ns/1ps
module key_event_queue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, rel = 1'b0, err_a = 1'b0, err_o = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [6:0] code = '0;
  logic [4:0] peek_off = '0;
  logic [7:0] pop_data, peek_data;
  logic key_ev, ovf;
  logic [4:0] level;

  int total = 0, fails = 0;
  logic [7:0] model [16];
  int mstart = 0, mlen = 0;

  always #4 clk = ~clk;

  key_event_queue uut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_code_i(code), .push_rel_i(rel),
    .err_active_i(err_a), .ovf_err_i(err_o), .pop_i(pop), .pop_data_o(pop_data),
    .peek_off_i(peek_off), .peek_data_o(peek_data), .flush_i(flush),
    .key_event_o(key_ev), .ovf_pulse_o(ovf), .level_o(level));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [6:0] c, input logic s,
                      input logic po, input logic fl, input string tag);
    logic lock, pop_ok, push_ok, exp_ovf;
    int exp_pd;
    @(negedge clk);
    push = p; code = c; rel = s; pop = po; flush = fl;
    #1;
    lock    = err_a & err_o;
    pop_ok  = po && mlen > 1 && !fl;
    push_ok = p && !lock && !fl && (mlen < 16 || pop_ok);
    exp_ovf = p && !lock && !fl && mlen == 16 && !pop_ok;
    exp_pd  = (mlen > 1) ? int'(model[(mstart + 1) % 16]) : 0;
    chk({tag, " key_event"}, int'(key_ev), int'(push_ok));
    chk({tag, " ovf_pulse"}, int'(ovf), int'(exp_ovf));
    if (po) chk({tag, " pop_data"}, int'(pop_data), exp_pd);
    @(posedge clk);
    if (fl) begin
      mstart = 0; mlen = 0;
    end else begin
      if (push_ok) model[(mstart + mlen) % 16] = {s, c};
      if (pop_ok) mstart = (mstart + 1) % 16;
      mlen = mlen + int'(push_ok) - int'(pop_ok);
    end
    #1;
    push = 0; pop = 0; flush = 0;
    chk({tag, " level"}, int'(level), mlen);
  endtask

  task automatic peek(input int k, input string tag);
    int exp;
    @(negedge clk);
    peek_off = 5'(k);
    #1;
    exp = (k < mlen) ? int'(model[(mstart + k) % 16]) : 0;
    chk({tag, " peek"}, int'(peek_data), exp);
  endtask

  task automatic t_reset;
    chk("R1 level", int'(level), 0);
    peek(0, "R1");
    peek(7, "R1");
  endtask

  task automatic t_basic;
    step(1, 7'h3c, 1, 0, 0, "R2");
    step(1, 7'h15, 0, 0, 0, "R2");
    step(1, 7'h7f, 1, 0, 0, "R2");
    peek(0, "R7"); peek(1, "R7"); peek(2, "R7"); peek(3, "R7"); peek(31, "R7");
    step(0, 0, 0, 1, 0, "R6");
    peek(0, "R6 serviced slot");
    peek(1, "R6");
  endtask

  task automatic t_pop_low;
    step(0, 0, 0, 0, 1, "R8");
    step(1, 7'h21, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, "R5");
    peek(0, "R5");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, 0, "R5 empty");
  endtask

  task automatic t_full;
    step(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 16; i++) step(1, 7'(i + 8'h40), i[0], 0, 0, "R2 fill");
    step(1, 7'h11, 1, 0, 0, "R3");
    peek(15, "R3");
    peek(16, "R7");
    step(1, 7'h55, 1, 1, 0, "R9");
    peek(15, "R9");
    peek(0, "R9");
  endtask

  task automatic t_lock;
    err_a = 1; err_o = 1;
    step(0, 0, 0, 0, 1, "R8");
    step(1, 7'h09, 0, 0, 0, "R4");
    err_o = 0;
    step(1, 7'h0a, 1, 0, 0, "R4 one bit");
    err_a = 0; err_o = 1;
    step(1, 7'h0b, 0, 0, 0, "R4 one bit");
    err_o = 0;
    peek(0, "R4"); peek(1, "R4");
  endtask

  task automatic t_wrap;
    step(0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 20; i++) begin
      step(1, 7'(i * 5), i[1], 0, 0, "R10 push");
      step(1, 7'(i * 3 + 1), i[0], 1, 0, "R10 push-pop");
      step(0, 0, 0, 1, 0, "R10 pop");
    end
    for (int k = 0; k < 4; k++) peek(k, "R10");
  endtask

  task automatic t_flush_prio;
    step(1, 7'h33, 0, 0, 0, "R2");
    step(1, 7'h34, 0, 0, 0, "R2");
    step(1, 7'h35, 1, 1, 1, "R8 prio");
    peek(0, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_basic;
    t_pop_low;
    t_full;
    t_lock;
    t_wrap;
    t_flush_prio;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule